// File: doc/BRIEF.md
# Unlock-Sequence Command Decoder for a Byte-Wide Flash Interface

This block is the synchronous command front end of a parallel, byte-wide flash device. A host writes to it with a write strobe that carries an address and a data byte. The decoder filters out strobes that are too short. It then follows the fixed unlock handshake: the key byte AAh at address 5555h, then the key byte 55h at address 2AAAh. After the handshake, a command byte selects an operation.

When a sequence completes, the decoder emits a one-cycle request that names the operation and carries its address and data. The operations are byte program, sector erase, full-array erase, identification-mode entry and identification-mode exit. The memory array and its timers lie outside the block.

A program or erase request sets an internal busy flag. The flag clears after the external array reports that it has started and then finished. While the flag or the external busy input is high, every write is dropped, and the sequence position is kept. In identification mode, reads at addresses 0 and 1 return fixed codes in place of the array data.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After synchronous reset: op_valid is 0, op_kind is 0, id_mode is 0, busy is 0, and the decoder waits for the first unlock write.
- R2: A write strobe (wr_en high) counts as a write only if it stays high for at least MIN_PULSE consecutive clocks. A shorter strobe has no effect on the sequence. The address is taken on the strobe's first high clock and the data on its last high clock.
- R3: Byte program takes four writes: AAh@5555h, 55h@2AAAh, A0h@5555h, then any address and data. The result is one op_valid pulse with op_kind=1, op_addr equal to the fourth write's address and op_data equal to its data. The pulse appears in the cycle after the clock edge that first samples the strobe low, plus one cycle.
- R4: Sector erase takes six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at any address. The result is op_kind=2, op_addr equal to that address with bits 11:0 cleared (4 KB sectors), and op_data=30h.
- R5: The same first five writes followed by 10h@5555h give op_kind=3, op_addr=0 and op_data=10h.
- R6: Unlock and command addresses are compared on bits 14:0 only. Higher address bits may take any value.
- R7: A write that does not match the expected address and data returns the decoder to its idle state and produces no request. A full sequence after that still works.
- R8: AAh@5555h, 55h@2AAAh, 90h@5555h give op_kind=4 and set id_mode. While id_mode is 1, a read with rd_addr bits above bit 0 all zero returns BFh at address 0 and DEV_CODE at address 1. Every other read returns arr_rdata.
- R9: A write of F0h at any address, in any state except the program-armed state, gives op_kind=5, clears id_mode and returns the decoder to idle. This also covers the three-write form that ends in F0h@5555h.
- R10: A request with op_kind 1, 2 or 3 sets busy in the next cycle. busy clears after busy_in has been seen high and then low. A write is dropped whenever busy or busy_in is high, and this includes F0h. The sequence position is kept across the busy period.
- R11: op_valid never lasts more than one cycle, and op_kind is 0 whenever op_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, active high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data byte |
| busy_in | input | 1 | Array reports that an internal operation is running |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | 8 | Byte read from the array |
| rd_data | output | 8 | Read result, with identification codes substituted |
| op_valid | output | 1 | One-cycle operation request |
| op_kind | output | 3 | 0 none, 1 program, 2 sector erase, 3 chip erase, 4 ID entry, 5 ID exit |
| op_addr | output | ADDR_W | Request address |
| op_data | output | 8 | Request data byte |
| id_mode | output | 1 | Identification mode active |
| busy | output | 1 | Internal operation in progress |

## Verification
The hardest situation to reach is a sequence that is interrupted by a busy period and must resume afterwards. The stimulus holds busy_in high by itself, with no preceding request, in the middle of an unlock handshake. It then sends writes that would otherwise abort the handshake, including F0h, and releases busy_in. The remaining writes must still complete a program request. A second hard case is an F0h written while identification mode is set and the busy flag from a program request is still high. id_mode must survive that write and clear only when F0h is written again after busy has dropped.

// File: rtl/cmd_decoder_pkg.sv
package cmd_decoder_pkg;

    localparam int CMP_W    = 15;
    localparam int SECT_LSB = 12;

    localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
    localparam logic [7:0] KEY_BYTE_A  = 8'hAA;
    localparam logic [7:0] KEY_BYTE_B  = 8'h55;
    localparam logic [7:0] CMD_PROG    = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_ID      = 8'h90;
    localparam logic [7:0] CMD_EXIT    = 8'hF0;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] MFR_CODE    = 8'hBF;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PROG     = 3'd1,
        OP_SECTOR   = 3'd2,
        OP_CHIP     = 3'd3,
        OP_ID_ENTER = 3'd4,
        OP_ID_EXIT  = 3'd5
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_ERASE_K0,
        ST_ERASE_K1,
        ST_ERASE_K2
    } seq_state_t;

    function automatic logic key_hit(input logic [CMP_W-1:0] a, input logic [7:0] d,
                                     input logic [CMP_W-1:0] ea, input logic [7:0] ed);
        return (a == ea) && (d == ed);
    endfunction

    function automatic logic is_array_op(input op_kind_t k);
        return (k == OP_PROG) || (k == OP_SECTOR) || (k == OP_CHIP);
    endfunction

endpackage

// File: rtl/cmd_strobe_filter.sv
module cmd_strobe_filter #(
    parameter int ADDR_W    = 17,
    parameter int MIN_PULSE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [7:0]        ev_data
);
    localparam int CNT_W = $clog2(MIN_PULSE + 1);

    logic              strobe_q;
    logic [ADDR_W-1:0] addr_lat;
    logic [7:0]        data_lat;
    logic              long_enough;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            addr_lat <= '0;
            data_lat <= '0;
        end else begin
            strobe_q <= wr_en;
            if (wr_en) begin
                data_lat <= wr_data;
                if (!strobe_q) addr_lat <= wr_addr;
            end
        end
    end

    generate
        if (MIN_PULSE <= 1) begin : g_no_filter
            assign long_enough = 1'b1;
        end else begin : g_counter
            logic [CNT_W-1:0] hi_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hi_cnt <= '0;
                end else if (wr_en) begin
                    if (!strobe_q)
                        hi_cnt <= CNT_W'(1);
                    else if (hi_cnt < CNT_W'(MIN_PULSE))
                        hi_cnt <= hi_cnt + 1'b1;
                end
            end
            assign long_enough = (hi_cnt >= CNT_W'(MIN_PULSE));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ev_valid <= 1'b0;
        else     ev_valid <= strobe_q && !wr_en && long_enough;
    end

    assign ev_addr = addr_lat;
    assign ev_data = data_lat;

endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmd_decoder_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [7:0]        ev_data,
    input  logic              ignore,
    output logic              op_valid,
    output op_kind_t          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode
);
    seq_state_t        state, nxt_state;
    logic              nxt_valid, nxt_id;
    op_kind_t          nxt_kind;
    logic [ADDR_W-1:0] nxt_addr;
    logic [7:0]        nxt_data;
    logic [CMP_W-1:0]  a_low;

    assign a_low = ev_addr[CMP_W-1:0];

    always_comb begin
        nxt_state = state;
        nxt_valid = 1'b0;
        nxt_kind  = OP_NONE;
        nxt_addr  = '0;
        nxt_data  = '0;
        nxt_id    = id_mode;
        if (ev_valid && !ignore) begin
            if (ev_data == CMD_EXIT && state != ST_PROG_ARM) begin
                nxt_valid = 1'b1;
                nxt_kind  = OP_ID_EXIT;
                nxt_data  = ev_data;
                nxt_id    = 1'b0;
                nxt_state = ST_IDLE;
            end else begin
                nxt_state = ST_IDLE;
                unique case (state)
                    ST_IDLE: if (key_hit(a_low, ev_data, KEY_ADDR_A, KEY_BYTE_A)) nxt_state = ST_KEY1;
                    ST_KEY1: if (key_hit(a_low, ev_data, KEY_ADDR_B, KEY_BYTE_B)) nxt_state = ST_KEY2;
                    ST_KEY2: begin
                        if (key_hit(a_low, ev_data, KEY_ADDR_A, CMD_PROG))
                            nxt_state = ST_PROG_ARM;
                        else if (key_hit(a_low, ev_data, KEY_ADDR_A, CMD_ERASE))
                            nxt_state = ST_ERASE_K0;
                        else if (key_hit(a_low, ev_data, KEY_ADDR_A, CMD_ID)) begin
                            nxt_valid = 1'b1;
                            nxt_kind  = OP_ID_ENTER;
                            nxt_data  = ev_data;
                            nxt_id    = 1'b1;
                        end
                    end
                    ST_PROG_ARM: begin
                        nxt_valid = 1'b1;
                        nxt_kind  = OP_PROG;
                        nxt_addr  = ev_addr;
                        nxt_data  = ev_data;
                    end
                    ST_ERASE_K0: if (key_hit(a_low, ev_data, KEY_ADDR_A, KEY_BYTE_A)) nxt_state = ST_ERASE_K1;
                    ST_ERASE_K1: if (key_hit(a_low, ev_data, KEY_ADDR_B, KEY_BYTE_B)) nxt_state = ST_ERASE_K2;
                    ST_ERASE_K2: begin
                        if (ev_data == CMD_SECTOR) begin
                            nxt_valid = 1'b1;
                            nxt_kind  = OP_SECTOR;
                            nxt_addr  = {ev_addr[ADDR_W-1:SECT_LSB], SECT_LSB'(0)};
                            nxt_data  = ev_data;
                        end else if (key_hit(a_low, ev_data, KEY_ADDR_A, CMD_CHIP)) begin
                            nxt_valid = 1'b1;
                            nxt_kind  = OP_CHIP;
                            nxt_data  = ev_data;
                        end
                    end
                    default: nxt_state = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op_valid <= 1'b0;
            op_kind  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
            id_mode  <= 1'b0;
        end else begin
            state    <= nxt_state;
            op_valid <= nxt_valid;
            op_kind  <= nxt_kind;
            op_addr  <= nxt_addr;
            op_data  <= nxt_data;
            id_mode  <= nxt_id;
        end
    end

endmodule

// File: rtl/cmd_busy_track.sv
module cmd_busy_track
    import cmd_decoder_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_valid,
    input  op_kind_t op_kind,
    input  logic     busy_in,
    output logic     busy
);
    logic seen_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            seen_run <= 1'b0;
        end else if (op_valid && is_array_op(op_kind)) begin
            busy     <= 1'b1;
            seen_run <= 1'b0;
        end else if (busy) begin
            if (busy_in)
                seen_run <= 1'b1;
            else if (seen_run)
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/cmd_id_readmux.sv
module cmd_id_readmux
    import cmd_decoder_pkg::*;
#(
    parameter int          ADDR_W   = 17,
    parameter logic [7:0]  DEV_CODE = 8'hB5
) (
    input  logic              id_mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data
);
    logic id_window;

    assign id_window = id_mode && (rd_addr[ADDR_W-1:1] == '0);

    always_comb begin
        if (id_window)
            rd_data = rd_addr[0] ? DEV_CODE : MFR_CODE;
        else
            rd_data = arr_rdata;
    end

endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import cmd_decoder_pkg::*;
#(
    parameter int         ADDR_W    = 17,
    parameter int         MIN_PULSE = 2,
    parameter logic [7:0] DEV_CODE  = 8'hB5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy_in,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_rdata,
    output logic [7:0]        rd_data,
    output logic              op_valid,
    output logic [2:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [7:0]        op_data,
    output logic              id_mode,
    output logic              busy
);
    logic              ev_valid;
    logic [ADDR_W-1:0] ev_addr;
    logic [7:0]        ev_data;
    op_kind_t          kind_q;
    logic              drop_writes;

    assign drop_writes = busy | busy_in;
    assign op_kind     = kind_q;

    cmd_strobe_filter #(.ADDR_W(ADDR_W), .MIN_PULSE(MIN_PULSE)) u_filter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    cmd_seq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data),
        .ignore(drop_writes), .op_valid(op_valid), .op_kind(kind_q), .op_addr(op_addr),
        .op_data(op_data), .id_mode(id_mode)
    );

    cmd_busy_track u_busy (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(kind_q),
        .busy_in(busy_in), .busy(busy)
    );

    cmd_id_readmux #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_rdmux (
        .id_mode(id_mode), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data)
    );

endmodule

// File: rtl/cmd_decoder_checker.sv
module cmd_decoder_checker
    import cmd_decoder_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic                clk,
    input logic                rst,
    input logic                busy_in,
    input logic                op_valid,
    input logic [2:0]          op_kind,
    input logic [SECT_LSB-1:0] op_addr_lo,
    input logic                id_mode,
    input logic                busy,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [7:0]          rd_data
);
    // R1: state right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!op_valid && !busy && !id_mode));

    // R11: single-cycle request
    assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);

    // R11: no kind without a request
    assert_kind_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (op_kind == OP_NONE));

    // R4: sector requests are aligned
    assert_sector_align_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_SECTOR) |-> (op_addr_lo == '0));

    // R10: array requests raise busy
    assert_busy_after_op_R10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_kind == OP_PROG || op_kind == OP_SECTOR || op_kind == OP_CHIP)) |=> busy);

    // R10: nothing issued while busy
    assert_no_op_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !op_valid);

    // R10: external busy blocks the next request
    assert_busy_in_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        busy_in |=> !op_valid);

    // R8: entry sets identification mode
    assert_id_enter_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ID_ENTER) |-> id_mode);

    // R9: exit clears identification mode
    assert_id_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == OP_ID_EXIT) |-> !id_mode);

    // R8: manufacturer code at address 0
    assert_id_read_R8: assert property (@(posedge clk) disable iff (rst)
        (id_mode && rd_addr == '0) |-> (rd_data == MFR_CODE));

endmodule

bind unlock_cmd_decoder cmd_decoder_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .busy_in(busy_in), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr_lo(op_addr[11:0]), .id_mode(id_mode), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/unlock_cmd_decoder_bench.sv
`timescale 1ns/1ps
module unlock_cmd_decoder_bench;
    localparam int AW   = 17;
    localparam int MINP = 2;
    localparam logic [7:0] DEV = 8'hB5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic busy_in = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] rd_data;
    logic op_valid;
    logic [2:0] op_kind;
    logic [AW-1:0] op_addr;
    logic [7:0] op_data;
    logic id_mode;
    logic busy;

    always #2 clk = ~clk;

    unlock_cmd_decoder #(.ADDR_W(AW), .MIN_PULSE(MINP), .DEV_CODE(DEV)) u_unlock_cmd_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy_in(busy_in), .rd_addr(rd_addr), .arr_rdata(arr_rdata), .rd_data(rd_data),
        .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .id_mode(id_mode), .busy(busy)
    );

    int checks = 0;
    int errors = 0;
    int op_count = 0;
    int last_kind = 0;
    logic [AW-1:0] last_addr = '0;
    logic [7:0] last_data = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_step = 0, m_cnt = 0;
    bit m_prev = 0, m_ev = 0, m_id = 0, m_busy = 0, m_seen = 0;
    logic [AW-1:0] m_a = '0, m_ev_a = '0;
    logic [7:0] m_d = '0, m_ev_d = '0;
    bit e_v = 0;
    int e_k = 0;
    logic [AW-1:0] e_a = '0;
    logic [7:0] e_d = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_step = 0; m_cnt = 0; m_prev = 0; m_ev = 0; m_id = 0; m_busy = 0; m_seen = 0;
            m_a = '0; m_d = '0; m_ev_a = '0; m_ev_d = '0;
            e_v = 0; e_k = 0; e_a = '0; e_d = '0;
        end else begin
            bit old_busy, fire, nev;
            int low;
            old_busy = m_busy;
            if (e_v && e_k >= 1 && e_k <= 3) begin m_busy = 1; m_seen = 0; end
            else if (m_busy) begin
                if (busy_in) m_seen = 1;
                else if (m_seen) m_busy = 0;
            end
            e_v = 0; e_k = 0; e_a = '0; e_d = '0;
            fire = m_ev && !old_busy && !busy_in;
            low = int'(m_ev_a & 17'h07FFF);
            if (fire) begin
                if (m_ev_d == 8'hF0 && m_step != 3) begin
                    e_v = 1; e_k = 5; e_d = 8'hF0; m_id = 0; m_step = 0;
                end else if (m_step == 0) m_step = (m_ev_d == 8'hAA && low == 'h5555) ? 1 : 0;
                else if (m_step == 1) m_step = (m_ev_d == 8'h55 && low == 'h2AAA) ? 2 : 0;
                else if (m_step == 2) begin
                    m_step = 0;
                    if (low == 'h5555 && m_ev_d == 8'hA0) m_step = 3;
                    else if (low == 'h5555 && m_ev_d == 8'h80) m_step = 4;
                    else if (low == 'h5555 && m_ev_d == 8'h90) begin e_v = 1; e_k = 4; e_d = 8'h90; m_id = 1; end
                end else if (m_step == 3) begin
                    e_v = 1; e_k = 1; e_a = m_ev_a; e_d = m_ev_d; m_step = 0;
                end else if (m_step == 4) m_step = (m_ev_d == 8'hAA && low == 'h5555) ? 5 : 0;
                else if (m_step == 5) m_step = (m_ev_d == 8'h55 && low == 'h2AAA) ? 6 : 0;
                else begin
                    m_step = 0;
                    if (m_ev_d == 8'h30) begin e_v = 1; e_k = 2; e_a = (m_ev_a >> 12) << 12; e_d = 8'h30; end
                    else if (m_ev_d == 8'h10 && low == 'h5555) begin e_v = 1; e_k = 3; e_d = 8'h10; end
                end
            end
            nev = m_prev && !wr_en && (m_cnt >= MINP);
            if (wr_en) begin
                if (!m_prev) begin m_a = wr_addr; m_cnt = 1; end
                else m_cnt = m_cnt + 1;
                m_d = wr_data;
            end
            m_prev = wr_en;
            m_ev = nev; m_ev_a = m_a; m_ev_d = m_d;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            logic [7:0] exp_rd;
            exp_rd = (m_id && (rd_addr >> 1) == 0) ? (rd_addr[0] ? DEV : 8'hBF) : arr_rdata;
            chk("R11 op_valid", {31'd0, op_valid}, {31'd0, e_v});
            chk("R11 op_kind", {29'd0, op_kind}, e_k);
            chk("R3 op_addr", {15'd0, op_addr}, {15'd0, e_a});
            chk("R3 op_data", {24'd0, op_data}, {24'd0, e_d});
            chk("R8 id_mode", {31'd0, id_mode}, {31'd0, m_id});
            chk("R10 busy", {31'd0, busy}, {31'd0, m_busy});
            chk("R8 rd_data", {24'd0, rd_data}, {24'd0, exp_rd});
            if (op_valid) begin
                op_count++; last_kind = op_kind; last_addr = op_addr; last_data = op_data;
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic strobe(input logic [AW-1:0] a, input logic [7:0] d, input int len);
        @(posedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
        repeat (len) @(posedge clk);
        #1; wr_en = 0; wr_addr = '0; wr_data = '0;
        repeat (2) @(posedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        strobe(a, d, 3);
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic busy_cycle();
        @(posedge clk); #1; busy_in = 1;
        repeat (5) @(posedge clk);
        #1; busy_in = 0;
        repeat (3) @(posedge clk);
    endtask

    task automatic unlock();
        wr(17'h05555, 8'hAA);
        wr(17'h02AAA, 8'h55);
    endtask

    task automatic read_at(input logic [AW-1:0] a, input logic [7:0] arr);
        @(posedge clk); #1; rd_addr = a; arr_rdata = arr;
        @(negedge clk);
    endtask

    int base;

    initial begin
        repeat (3) @(posedge clk);
        #1; rst = 0;
        @(negedge clk);
        chk("R1 op_valid", {31'd0, op_valid}, 0);
        chk("R1 id_mode", {31'd0, id_mode}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 op_kind", {29'd0, op_kind}, 0);

        // R3 program, with address skew inside the data strobe (R2 capture points)
        unlock(); wr(17'h05555, 8'hA0);
        @(posedge clk); #1; wr_en = 1; wr_addr = 17'h01234; wr_data = 8'h00;
        @(posedge clk); #1; wr_addr = 17'h1FFFF;
        @(posedge clk); #1; wr_data = 8'h5A;
        @(posedge clk); #1; wr_en = 0;
        settle();
        chk("R3 program kind", last_kind, 1);
        chk("R3 program addr", {15'd0, last_addr}, 32'h01234);
        chk("R2 program data on last strobe clock", {24'd0, last_data}, 32'h5A);
        busy_cycle();
        chk("R10 busy released", {31'd0, busy}, 0);

        // R6 upper address bits ignored on unlock
        wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h18000 | 17'h5555, 8'hA0);
        wr(17'h10077, 8'hC3);
        settle();
        chk("R6 program with high bits", last_kind, 1);
        chk("R6 program addr", {15'd0, last_addr}, 32'h10077);
        busy_cycle();

        // R2 glitch inside a sequence is ignored
        base = op_count;
        wr(17'h05555, 8'hAA); strobe(17'h00000, 8'h12, 1); wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0); wr(17'h00400, 8'h77);
        settle();
        chk("R2 glitch skipped", op_count - base, 1);
        busy_cycle();
        // R2 glitched first key does not start a sequence
        base = op_count;
        strobe(17'h05555, 8'hAA, 1); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h00401, 8'h01);
        settle();
        chk("R2 glitch key no op", op_count - base, 0);

        // R7 wrong cycle aborts
        base = op_count;
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h54); wr(17'h02AAA, 8'h55);
        wr(17'h05555, 8'hA0); wr(17'h00500, 8'h22);
        settle();
        chk("R7 abort no op", op_count - base, 0);
        unlock(); wr(17'h05555, 8'h91); wr(17'h00000, 8'h01);
        settle();
        chk("R7 bad command no op", op_count - base, 0);

        // R4 sector erase
        unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h1ABCD, 8'h30);
        settle();
        chk("R4 sector kind", last_kind, 2);
        chk("R4 sector addr", {15'd0, last_addr}, 32'h1A000);
        // R10 writes ignored while busy flag high, including F0
        base = op_count;
        wr(17'h00000, 8'hF0); unlock(); wr(17'h05555, 8'hA0); wr(17'h00010, 8'h10);
        chk("R10 ignored while busy", op_count - base, 0);
        busy_cycle();

        // R5 chip erase
        unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10);
        settle();
        chk("R5 chip kind", last_kind, 3);
        chk("R5 chip addr", {15'd0, last_addr}, 0);
        busy_cycle();

        // R8 id entry and reads
        unlock(); wr(17'h05555, 8'h90);
        settle();
        chk("R8 enter kind", last_kind, 4);
        chk("R8 id_mode set", {31'd0, id_mode}, 1);
        read_at(17'h00000, 8'h11); chk("R8 manufacturer code", {24'd0, rd_data}, 32'hBF);
        read_at(17'h00001, 8'h11); chk("R8 device code", {24'd0, rd_data}, {24'd0, DEV});
        read_at(17'h00002, 8'h6E); chk("R8 array read in id", {24'd0, rd_data}, 32'h6E);
        // R9 single-write exit
        wr(17'h00333, 8'hF0);
        settle();
        chk("R9 exit kind", last_kind, 5);
        chk("R9 id_mode cleared", {31'd0, id_mode}, 0);
        read_at(17'h00000, 8'h42); chk("R8 array read normal", {24'd0, rd_data}, 32'h42);
        // R9 three-write exit
        unlock(); wr(17'h05555, 8'h90); unlock(); wr(17'h05555, 8'hF0);
        settle();
        chk("R9 three-write exit", {31'd0, id_mode}, 0);

        // R10 F0 dropped while busy in id mode
        unlock(); wr(17'h05555, 8'h90);
        unlock(); wr(17'h05555, 8'hA0); wr(17'h00020, 8'h33);
        wr(17'h00000, 8'hF0);
        settle();
        chk("R10 F0 ignored while busy", {31'd0, id_mode}, 1);
        busy_cycle();
        wr(17'h00000, 8'hF0);
        settle();
        chk("R9 exit after busy", {31'd0, id_mode}, 0);

        // R10 sequence position held across busy_in
        base = op_count;
        unlock();
        @(posedge clk); #1; busy_in = 1;
        wr(17'h00000, 8'hF0); wr(17'h00000, 8'h00);
        @(posedge clk); #1; busy_in = 0;
        wr(17'h05555, 8'hA0); wr(17'h00600, 8'h99);
        settle();
        chk("R10 resume after busy_in", op_count - base, 1);
        chk("R10 resumed program kind", last_kind, 1);
        busy_cycle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule